// File: doc/BRIEF.md
# Redial and Save Digit Memory Controller

This block sits between a telephone keypad decoder and a tone/pulse dialing engine. It keeps two digit memories of equal depth. The redial memory records every storable key of the current call, and the save memory holds a copy taken on request. Each entry is a 4-bit symbol: a digit, the star/tone-switch symbol, hash, or a pause. Keys reach the dialer through a valid/ready symbol stream. On a redial command the controller replays a stored sequence on that same stream, one symbol per handshake.

The combined redial/pause key changes meaning with its position in the call. As the first key after going off-hook it replays the redial memory. At any later point it inserts a pause. Two pause lengths can be keyed, but memory keeps only one pause code. Dialing past the memory depth is allowed. The extra keys are still sent to the dialer, but an overflow mark is set. That mark inhibits redial and save, so a truncated number is never replayed.

A dedicated one-key redial shares the redial memory. When it is not the first key, a line-break symbol is sent ahead of the replay. A recall key replays the save memory and rewrites the redial memory with what it plays. Memory contents persist across on-hook periods.

Top module: `dial_memory_ctrl`

## Requirements
- R1: While off-hook and idle, digit keys 0-9, star (10) and hash (11) are sent on the stream as the same 4-bit symbol code and appended to the redial memory. The first such key after going off-hook restarts the memory at entry 0.
- R2: The redial memory holds DEPTH (32) entries. Further recordable keys are still sent but are not stored, and they set an overflow mark. While the mark is set, redial by either key and save are ignored. Filling exactly DEPTH entries does not set the mark.
- R3: The short-pause key (12) or the long-pause key (13), pressed as the first accepted key after going off-hook, replays the redial memory from entry 0 up to its stored length, one symbol per handshake. When the memory is empty or overflowed, that press is ignored.
- R4: The same keys pressed later in a call send a pause symbol (12 for the short key, 13 for the long key), and both store the single pause code 12.
- R5: The flash key (14) sends symbol 15. It is never stored and it leaves the first-key status unchanged.
- R6: The save key (15) copies the redial memory's content and length into the save memory when the dialer-finished input is high. While that input is low, the save key is ignored.
- R7: The one-key redial key (16) requires the dialer-finished input to be high and is ignored otherwise. As the first key after off-hook it replays the redial memory. Later in a call it first sends the break symbol 14 and then replays the redial memory.
- R8: The recall key (17) replays the save memory, when that memory is not empty. The redial memory is rewritten with the replayed entries, so a later redial repeats the recalled number.
- R9: symValid stays high with a stable symCode until symReady is high. A key is ignored when it arrives while a symbol is pending and not being accepted in that cycle, or while a replay is running.
- R10: Going on-hook drops symValid in the next cycle, aborts any replay, ignores keys and re-arms the first-key status. Memory contents are kept.
- R11: After reset symValid is low and both memories are empty, so redial and recall commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| offHook | input | 1 | Debounced hook state, 1 = off-hook |
| keyValid | input | 1 | One-cycle strobe for a decoded key |
| keyCode | input | 5 | Key code (0-11 symbols, 12/13 redial-pause, 14 flash, 15 save, 16 one-key redial, 17 recall) |
| dialDone | input | 1 | Dialer has finished sending all earlier digits |
| symReady | input | 1 | Dialer accepts the pending symbol |
| symValid | output | 1 | A symbol is pending for the dialer |
| symCode | output | 4 | Pending symbol (0-11, 12 pause, 13 long pause, 14 break, 15 flash) |

## Verification
Two situations can fall in the same cycle. In the first, a new key arrives in the very cycle the dialer accepts the pending symbol. The key must then be taken, while the same key one cycle earlier must be dropped. In the second, the hook goes on-hook in the cycle a replay step would load the next entry, and the flush must win. Both are provoked by stalling or randomly toggling symReady while pressing keys during pending symbols and running replays, and by dropping the hook in the middle of a replay. A behavioural queue model judges every cycle's symValid and symCode, and short directed scenarios also compare the complete accepted symbol stream.

// File: rtl/dial_memory_pkg.sv
package dial_memory_pkg;

  localparam int KEY_W = 5;
  localparam int SYM_W = 4;

  // key codes from the keypad decoder
  localparam logic [KEY_W-1:0] KEY_HASH     = KEY_W'(11);
  localparam logic [KEY_W-1:0] KEY_RP_SHORT = KEY_W'(12);
  localparam logic [KEY_W-1:0] KEY_RP_LONG  = KEY_W'(13);
  localparam logic [KEY_W-1:0] KEY_FLASH    = KEY_W'(14);
  localparam logic [KEY_W-1:0] KEY_SAVE     = KEY_W'(15);
  localparam logic [KEY_W-1:0] KEY_REDIAL   = KEY_W'(16);
  localparam logic [KEY_W-1:0] KEY_RECALL   = KEY_W'(17);

  // symbols towards the dialer
  localparam logic [SYM_W-1:0] SYM_PAUSE = SYM_W'(12);
  localparam logic [SYM_W-1:0] SYM_BREAK = SYM_W'(14);
  localparam logic [SYM_W-1:0] SYM_FLASH = SYM_W'(15);

  typedef enum logic {ST_IDLE, ST_PLAY} ctl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             recStrobe;
    logic             recFresh;
    logic [SYM_W-1:0] recCode;
    logic             emitStrobe;
    logic [SYM_W-1:0] emitCode;
    logic             copyStrobe;
    logic             playStart;
    logic             playSrcSave;
    logic             playBreak;
    logic             playStep;
    logic             outFlush;
  } dm_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic slotFree;
    logic playMore;
    logic redEmpty;
    logic redOvf;
    logic saveEmpty;
  } dm_stat_t;

endpackage

// File: rtl/dial_memory_datapath.sv
module dial_memory_datapath
  import dial_memory_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dm_ctl_t          ctl,
  input  logic             symReady,
  output dm_stat_t         stat,
  output logic             symValid,
  output logic [SYM_W-1:0] symCode
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

  logic [SYM_W-1:0] redMem  [DEPTH];
  logic [SYM_W-1:0] saveMem [DEPTH];
  logic [LEN_W-1:0] redLen, saveLen, playIdx, srcLen;
  logic             redOvf, playSave;
  logic             fire;
  logic [SYM_W-1:0] srcSym;
  logic             redWe;
  logic [IDX_W-1:0] redWa;
  logic [SYM_W-1:0] redWd;

  assign fire   = symValid && symReady;
  assign srcLen = playSave ? saveLen : redLen;
  assign srcSym = playSave ? saveMem[playIdx[IDX_W-1:0]] : redMem[playIdx[IDX_W-1:0]];

  assign stat.slotFree  = !symValid || fire;
  assign stat.playMore  = playIdx < srcLen;
  assign stat.redEmpty  = (redLen == '0);
  assign stat.redOvf    = redOvf;
  assign stat.saveEmpty = (saveLen == '0);

  // redial memory write port: live recording or rewrite during recall
  always_comb begin
    redWe = 1'b0;
    redWa = '0;
    redWd = ctl.recCode;
    if (ctl.recStrobe) begin
      if (ctl.recFresh) begin
        redWe = 1'b1;
      end else if (redLen < FULL) begin
        redWe = 1'b1;
        redWa = redLen[IDX_W-1:0];
      end
    end else if (ctl.playStep && playSave) begin
      redWe = 1'b1;
      redWa = playIdx[IDX_W-1:0];
      redWd = srcSym;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) begin
        redMem[i]  <= '0;
        saveMem[i] <= '0;
      end else begin
        if (redWe && redWa == IDX_W'(i)) redMem[i] <= redWd;
        if (ctl.copyStrobe) saveMem[i] <= redMem[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redLen  <= '0;
      redOvf  <= 1'b0;
      saveLen <= '0;
    end else begin
      if (ctl.recStrobe) begin
        if (ctl.recFresh) begin
          redLen <= LEN_W'(1);
          redOvf <= 1'b0;
        end else if (redLen < FULL) begin
          redLen <= redLen + 1'b1;
        end else begin
          redOvf <= 1'b1;
        end
      end else if (ctl.playStart && ctl.playSrcSave) begin
        redLen <= '0;
        redOvf <= 1'b0;
      end else if (ctl.playStep && playSave) begin
        redLen <= playIdx + 1'b1;
      end
      if (ctl.copyStrobe) saveLen <= redLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      playIdx  <= '0;
      playSave <= 1'b0;
    end else if (ctl.playStart) begin
      playIdx  <= '0;
      playSave <= ctl.playSrcSave;
    end else if (ctl.playStep) begin
      playIdx  <= playIdx + 1'b1;
    end
  end

  // output symbol register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      symValid <= 1'b0;
      symCode  <= '0;
    end else if (ctl.outFlush) begin
      symValid <= 1'b0;
    end else if (ctl.emitStrobe) begin
      symValid <= 1'b1;
      symCode  <= ctl.emitCode;
    end else if (ctl.playStart && ctl.playBreak) begin
      symValid <= 1'b1;
      symCode  <= SYM_BREAK;
    end else if (ctl.playStep) begin
      symValid <= 1'b1;
      symCode  <= srcSym;
    end else if (fire) begin
      symValid <= 1'b0;
    end
  end

  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    redOvf |-> redLen == FULL); // R2
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (redLen <= FULL) && (saveLen <= FULL)); // R2
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && !symReady && !ctl.outFlush) |=> (symValid && $stable(symCode))); // R9
  AST_STORE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.recStrobe |-> (ctl.recCode <= SYM_PAUSE)); // R5

endmodule

// File: rtl/dial_memory_control.sv
module dial_memory_control
  import dial_memory_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             offHook,
  input  logic             keyValid,
  input  logic [KEY_W-1:0] keyCode,
  input  logic             dialDone,
  input  dm_stat_t         stat,
  output dm_ctl_t          ctl
);

  ctl_state_e state, nextState;
  logic       firstKey, nextFirst;
  logic       keyTake, redOk;

  assign keyTake = keyValid && offHook && (state == ST_IDLE) && stat.slotFree;
  assign redOk   = !stat.redEmpty && !stat.redOvf;

  always_comb begin
    ctl          = '0;
    ctl.outFlush = !offHook;
    nextState    = state;
    nextFirst    = firstKey;
    if (!offHook) begin
      nextState = ST_IDLE;
      nextFirst = 1'b1;
    end else if (state == ST_PLAY) begin
      if (stat.slotFree) begin
        if (stat.playMore) ctl.playStep = 1'b1;
        else               nextState    = ST_IDLE;
      end
    end else if (keyTake) begin
      if (keyCode <= KEY_HASH) begin
        ctl.recStrobe  = 1'b1;
        ctl.recFresh   = firstKey;
        ctl.recCode    = keyCode[SYM_W-1:0];
        ctl.emitStrobe = 1'b1;
        ctl.emitCode   = keyCode[SYM_W-1:0];
        nextFirst      = 1'b0;
      end else if (keyCode == KEY_RP_SHORT || keyCode == KEY_RP_LONG) begin
        if (firstKey) begin
          if (redOk) begin
            ctl.playStart = 1'b1;
            nextState     = ST_PLAY;
            nextFirst     = 1'b0;
          end
        end else begin
          ctl.recStrobe  = 1'b1;
          ctl.recCode    = SYM_PAUSE;
          ctl.emitStrobe = 1'b1;
          ctl.emitCode   = keyCode[SYM_W-1:0];
        end
      end else if (keyCode == KEY_FLASH) begin
        ctl.emitStrobe = 1'b1;
        ctl.emitCode   = SYM_FLASH;
      end else if (keyCode == KEY_SAVE) begin
        ctl.copyStrobe = dialDone && redOk;
      end else if (keyCode == KEY_REDIAL) begin
        if (dialDone && redOk) begin
          ctl.playStart = 1'b1;
          ctl.playBreak = !firstKey;
          nextState     = ST_PLAY;
          nextFirst     = 1'b0;
        end
      end else if (keyCode == KEY_RECALL) begin
        if (!stat.saveEmpty) begin
          ctl.playStart   = 1'b1;
          ctl.playSrcSave = 1'b1;
          nextState       = ST_PLAY;
          nextFirst       = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      firstKey <= 1'b1;
    end else begin
      state    <= nextState;
      firstKey <= nextFirst;
    end
  end

  AST_ONHOOK_REARM: assert property (@(posedge clk) disable iff (!rstN)
    !offHook |=> (firstKey && state == ST_IDLE)); // R10

endmodule

// File: rtl/dial_memory_ctrl.sv
module dial_memory_ctrl
  import dial_memory_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             offHook,
  input  logic             keyValid,
  input  logic [KEY_W-1:0] keyCode,
  input  logic             dialDone,
  input  logic             symReady,
  output logic             symValid,
  output logic [SYM_W-1:0] symCode
);

  dm_ctl_t  ctl;
  dm_stat_t stat;

  dial_memory_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .offHook  (offHook),
    .keyValid (keyValid),
    .keyCode  (keyCode),
    .dialDone (dialDone),
    .stat     (stat),
    .ctl      (ctl)
  );

  dial_memory_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .symReady (symReady),
    .stat     (stat),
    .symValid (symValid),
    .symCode  (symCode)
  );

  AST_ONHOOK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !offHook |=> !symValid); // R10

endmodule

// File: tb/dial_memory_ctrl_tb_top.sv
module dial_memory_ctrl_tb_top;

  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rstN, offHook, keyValid, dialDone, symReady;
  logic [4:0] keyCode;
  logic       symValid;
  logic [3:0] symCode;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string curReq = "R11";
  bit    rdyRand = 0;
  bit    rdyForce = 1;

  // reference model state
  bit mValid = 0, mPlay = 0, mSrcSave = 0, mFirst = 1, mOvf = 0;
  int mCode = 0, mIdx = 0;
  int redQ[$];
  int saveQ[$];
  bit mFire, mFree;
  int mK, mN;

  int got[$];
  int expQ[$];

  always #4 clk = ~clk;

  dial_memory_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .offHook(offHook), .keyValid(keyValid),
    .keyCode(keyCode), .dialDone(dialDone), .symReady(symReady),
    .symValid(symValid), .symCode(symCode)
  );

  task automatic mRec(int c);
    if (mFirst) begin
      redQ.delete();
      redQ.push_back(c);
      mOvf = 0;
    end else if (redQ.size() < DEPTH) begin
      redQ.push_back(c);
    end else begin
      mOvf = 1;
    end
  endtask

  task automatic mStart(bit src, bit brk);
    mPlay = 1; mSrcSave = src; mIdx = 0; mValid = brk;
    if (brk) mCode = 14;
  endtask

  // behavioural reference model, advanced on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0; mPlay = 0; mSrcSave = 0; mFirst = 1; mOvf = 0; mIdx = 0; mCode = 0;
      redQ.delete(); saveQ.delete();
    end else begin
      mFire = mValid && symReady;
      mFree = !mValid || mFire;
      if (!offHook) begin
        mValid = 0; mPlay = 0; mFirst = 1;
      end else if (mPlay) begin
        if (mFree) begin
          mN = mSrcSave ? saveQ.size() : redQ.size();
          if (mIdx < mN) begin
            mCode = mSrcSave ? saveQ[mIdx] : redQ[mIdx];
            mValid = 1;
            if (mSrcSave) redQ.push_back(mCode);
            mIdx++;
          end else begin
            mPlay = 0; mValid = 0;
          end
        end
      end else begin
        if (mFire) mValid = 0;
        if (keyValid && mFree) begin
          mK = keyCode;
          if (mK <= 11) begin
            mRec(mK); mValid = 1; mCode = mK; mFirst = 0;
          end else if (mK == 12 || mK == 13) begin
            if (mFirst) begin
              if (redQ.size() > 0 && !mOvf) begin mStart(0, 0); mFirst = 0; end
            end else begin
              mRec(12); mValid = 1; mCode = mK;
            end
          end else if (mK == 14) begin
            mValid = 1; mCode = 15;
          end else if (mK == 15) begin
            if (dialDone && redQ.size() > 0 && !mOvf) saveQ = redQ;
          end else if (mK == 16) begin
            if (dialDone && redQ.size() > 0 && !mOvf) begin mStart(0, !mFirst); mFirst = 0; end
          end else if (mK == 17) begin
            if (saveQ.size() > 0) begin redQ.delete(); mOvf = 0; mStart(1, 0); mFirst = 0; end
          end
        end
      end
    end
  end

  // per-cycle comparison and stream capture, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (symValid !== mValid || (mValid && symCode !== 4'(mCode))) begin
        failures++;
        $display("FAIL %s per-cycle: symValid=%0b symCode=%0d expected %0b/%0d",
                 curReq, symValid, symCode, mValid, mCode);
      end
      if (symValid && symReady) got.push_back(int'(symCode));
    end
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      symReady = rdyRand ? 1'($urandom_range(0, 1)) : rdyForce;
    end
  end

  task automatic press(int k);
    @(posedge clk); #2;
    keyValid = 1'b1; keyCode = 5'(k);
    @(posedge clk); #2;
    keyValid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    repeat (2) @(posedge clk);
    while ((mPlay || mValid) && guard < 500) begin
      @(posedge clk);
      guard++;
    end
    repeat (2) @(posedge clk);
  endtask

  task automatic hookCycle();
    @(posedge clk); #2 offHook = 1'b0;
    repeat (3) @(posedge clk);
    #2 offHook = 1'b1;
  endtask

  task automatic chkStream(string req);
    bit bad = 0;
    checks++;
    if (got.size() != expQ.size()) bad = 1;
    else foreach (got[i]) if (got[i] != expQ[i]) bad = 1;
    if (bad) begin
      failures++;
      $display("FAIL %s stream: got %0d symbols (first %0d) expected %0d symbols (first %0d)",
               req, got.size(), (got.size() > 0) ? got[0] : -1,
               expQ.size(), (expQ.size() > 0) ? expQ[0] : -1);
    end
    got.delete();
    expQ.delete();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    rstN = 0; offHook = 0; keyValid = 0; keyCode = '0; dialDone = 1; symReady = 1;
    repeat (4) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    checks++;
    if (symValid !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset: symValid=%0b expected 0", symValid);
    end

    // R11: empty memories, redial and recall do nothing
    curReq = "R11";
    @(posedge clk); #2 offHook = 1;
    press(16); press(17); press(12);
    drain();
    chkStream("R11");

    // R1: live digits, star, hash
    curReq = "R1";
    press(5); press(1); press(2); press(10); press(11);
    drain();
    expQ = {5, 1, 2, 10, 11};
    chkStream("R1");

    // R4: later redial/pause key inserts pause
    curReq = "R4";
    press(12); press(13);
    drain();
    expQ = {12, 13};
    chkStream("R4");

    // R5: flash sent, not stored
    curReq = "R5";
    press(14);
    drain();
    expQ = {15};
    chkStream("R5");

    // R3: first-key redial with random stalls; flash not stored, pauses as 12
    curReq = "R3";
    hookCycle();
    rdyRand = 1;
    press(12);
    drain();
    rdyRand = 0;
    drain();
    expQ = {5, 1, 2, 10, 11, 12, 12};
    chkStream("R3");

    // R9: key while symbol pending is dropped
    curReq = "R9";
    rdyForce = 0;
    press(3); press(4);
    repeat (3) @(posedge clk);
    rdyForce = 1;
    drain();
    expQ = {3};
    chkStream("R9");
    // R9: key during replay is dropped
    hookCycle();
    press(13); press(9);
    drain();
    expQ = {5, 1, 2, 10, 11, 12, 12, 3};
    chkStream("R9");

    // R6: save ignored while dialing, then taken
    curReq = "R6";
    dialDone = 0;
    press(15);
    hookCycle();
    press(17);
    drain();
    chkStream("R6");
    dialDone = 1;
    press(15);
    hookCycle();
    press(17);
    drain();
    expQ = {5, 1, 2, 10, 11, 12, 12, 3};
    chkStream("R6");

    // R8: recall rewrites redial memory
    curReq = "R8";
    hookCycle();
    press(7); press(8);
    hookCycle();
    press(17);
    drain();
    got.delete();
    hookCycle();
    press(12);
    drain();
    expQ = {5, 1, 2, 10, 11, 12, 12, 3};
    chkStream("R8");

    // R7: one-key redial
    curReq = "R7";
    hookCycle();
    press(7); press(8);
    dialDone = 0;
    press(16);
    dialDone = 1;
    press(16);
    drain();
    expQ = {7, 8, 14, 7, 8};
    chkStream("R7");
    hookCycle();
    press(16);
    drain();
    expQ = {7, 8};
    chkStream("R7");

    // R2: exactly full memory still redials
    curReq = "R2";
    hookCycle();
    for (int i = 0; i < DEPTH; i++) press(i % 10);
    drain();
    got.delete();
    hookCycle();
    press(12);
    drain();
    for (int i = 0; i < DEPTH; i++) expQ.push_back(i % 10);
    chkStream("R2");
    // R2: overflow inhibits save and redial, still sends every digit
    hookCycle();
    for (int i = 0; i < DEPTH + 1; i++) press((i + 3) % 10);
    drain();
    for (int i = 0; i < DEPTH + 1; i++) expQ.push_back((i + 3) % 10);
    chkStream("R2");
    press(15); press(16);
    hookCycle();
    press(12);
    drain();
    chkStream("R2");
    press(17);
    drain();
    expQ = {5, 1, 2, 10, 11, 12, 12, 3};
    chkStream("R2");

    // R10: on-hook aborts replay, memory persists
    curReq = "R10";
    hookCycle();
    rdyForce = 0;
    press(12);
    repeat (2) @(posedge clk);
    #2 offHook = 0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (symValid !== 1'b0) begin
      failures++;
      $display("FAIL R10 on-hook flush: symValid=%0b expected 0", symValid);
    end
    rdyForce = 1;
    repeat (3) @(posedge clk);
    got.delete();
    #2 offHook = 1;
    press(12);
    drain();
    expQ = {5, 1, 2, 10, 11, 12, 12, 3};
    chkStream("R10");

    finishRun();
  end

endmodule